// File: doc/BRIEF.md
# Processor mode and privilege controller

This block holds the execution state of a small microcontroller core. It tracks whether the core is running ordinary program code (thread mode) or an exception handler (handler mode). It keeps one control bit that can drop thread code to an unprivileged level, and it records the number of the exception that is currently active. It decides the effective privilege from the mode and that bit, and it presents the exception number in a program status field.

The core's sequencer sends it exception-entry requests and exception-return strobes. Software reaches the control register through a write port and a read port. Handler code always runs privileged. Once thread code has given up privilege, it can only get it back through an exception: the handler clears the control bit, and privileged thread execution resumes after the return. Only one exception can be active at a time. Entry requests that arrive during a handler are dropped, not queued.

Top module: `exec_state_ctrl`

## Requirements
- R1: After reset the block is in thread mode (`in_handler` = 0), `priv_eff` = 1, the control read word is 0 and `psr_exc` is 0.
- R2: A control write with data bit 0 = 1, made in thread mode while privileged, makes `priv_eff` 0 from the clock edge that accepts the write.
- R3: While thread execution is unprivileged, control writes have no effect: bit 0 stays 1 and `priv_eff` stays 0.
- R4: An entry request in thread mode puts the block in handler mode at the next clock edge, and `priv_eff` is 1 throughout handler mode whatever control bit 0 holds.
- R5: A control write made in handler mode is always accepted, and the value decides the thread privilege after the return: bit 0 = 0 restores privileged thread execution, and bit 0 = 1 gives unprivileged thread execution.
- R6: An exception-return strobe in handler mode puts the block back in thread mode at the next clock edge.
- R7: `psr_exc` (EXC_W bits, 9 by default) holds the active exception number throughout handler mode and reads 0 in thread mode; when `exc_is_irq` = 0 the number is `exc_num` as given.
- R8: When `exc_is_irq` = 1, `exc_num` is an interrupt line index n and is recorded as n + IRQ_BASE (default 16), so line 3 reports 19.
- R9: The control read word carries the current control bit 0 in bit 0 at any privilege level or mode, and every other bit reads 0, whatever was written to the upper bits.
- R10: An entry request seen in handler mode is ignored and leaves the recorded number unchanged, and a return strobe seen in thread mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_req | input | 1 | Exception-entry request, one cycle |
| exc_is_irq | input | 1 | With exc_req: exc_num is an external interrupt line index |
| exc_num | input | EXC_W | Exception number or interrupt line index |
| exc_ret | input | 1 | Exception-return strobe, one cycle |
| ctl_wr_en | input | 1 | Control register write enable |
| ctl_wr_data | input | CTRL_W | Control register write data; only bit 0 is held |
| ctl_rd_data | output | CTRL_W | Control register read word |
| in_handler | output | 1 | 1 in handler mode, 0 in thread mode |
| priv_eff | output | 1 | Effective privilege of the current execution |
| psr_exc | output | EXC_W | Program status exception field |

## Verification
The bench uses the default parameters: a 9-bit exception field, a 32-bit control word and an interrupt base of 16. With these values it can reach the top exception number 511 directly and through interrupt line 495, and it can write all ones to the upper 31 control bits and confirm that they read back as zero. The directed sequences cover the privilege drop, the locked register, and recovery through a handler in both directions. They also check that nested entry requests are dropped and that a return strobe in thread mode does nothing.

// File: rtl/exec_state_pkg.sv
// Package: types shared by the execution-state controller.
// Assumes: none; holds only the mode encoding.
package exec_state_pkg;
    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } exec_mode_e;
endpackage

// File: rtl/mode_tracker.sv
// Module: mode_tracker
// Holds the execution mode and the number of the active exception.
// Assumes: one exception at a time. Entry is taken only from thread mode
// and return only from handler mode. Interrupt line indices are turned
// into exception numbers when the entry is taken.
module mode_tracker
    import exec_state_pkg::*;
#(
    parameter int EXC_W    = 9,
    parameter int IRQ_BASE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic             exc_is_irq,
    input  logic [EXC_W-1:0] exc_num,
    input  logic             exc_ret,
    output exec_mode_e       mode,
    output logic [EXC_W-1:0] act_exc
);
    localparam logic [EXC_W-1:0] IRQ_OFS = EXC_W'(IRQ_BASE);

    logic             take_entry;
    logic             take_ret;
    logic [EXC_W-1:0] entry_num;

    // Work out which strobes are legal in the current mode, and the number to record.
    always_comb begin
        take_entry = (mode == MODE_THREAD)  && exc_req;
        take_ret   = (mode == MODE_HANDLER) && exc_ret;
        entry_num  = exc_is_irq ? (exc_num + IRQ_OFS) : exc_num;
    end

    // Update the mode and the active exception number on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_THREAD;
            act_exc <= '0;
        end else if (take_entry) begin
            mode    <= MODE_HANDLER;
            act_exc <= entry_num;
        end else if (take_ret) begin
            mode    <= MODE_THREAD;
            act_exc <= '0;
        end
    end

    // R10: a nested entry request leaves the recorded number alone
    a_r10_nested_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HANDLER && exc_req && !exc_ret) |=> (mode == MODE_HANDLER) && $stable(act_exc))
        else $error("nested entry changed state");

    // R10: a return strobe in thread mode keeps thread mode
    a_r10_stray_return: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_THREAD && exc_ret && !exc_req) |=> (mode == MODE_THREAD))
        else $error("stray return changed mode");
endmodule

// File: rtl/priv_reg.sv
// Module: priv_reg
// Holds control bit 0, which makes thread execution unprivileged when set.
// Assumes: a write is judged by the mode and bit value before the edge.
// Handler code and privileged thread code may write; unprivileged thread
// code may not.
module priv_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic in_handler,
    input  logic wr_en,
    input  logic wr_bit0,
    output logic thread_unpriv
);
    logic wr_ok;

    // A write counts only when the current execution is privileged.
    always_comb begin
        wr_ok = wr_en && (in_handler || !thread_unpriv);
    end

    // Store the privilege bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thread_unpriv <= 1'b0;
        end else if (wr_ok) begin
            thread_unpriv <= wr_bit0;
        end
    end

    // R3: unprivileged thread code cannot clear the bit
    a_r3_locked_when_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && thread_unpriv) |=> thread_unpriv)
        else $error("unprivileged write took effect");

    // R2: a privileged thread write of 1 drops privilege
    a_r2_priv_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && !thread_unpriv && wr_en && wr_bit0) |=> thread_unpriv)
        else $error("privilege drop not taken");
endmodule

// File: rtl/status_view.sv
// Module: status_view
// Builds the visible outputs from the stored state: effective privilege,
// the program status exception field and the control read word.
// Assumes: purely combinational; the inputs come from registers.
module status_view #(
    parameter int EXC_W  = 9,
    parameter int CTRL_W = 32
) (
    input  logic              in_handler,
    input  logic              thread_unpriv,
    input  logic [EXC_W-1:0]  act_exc,
    output logic              priv_eff,
    output logic [EXC_W-1:0]  psr_exc,
    output logic [CTRL_W-1:0] ctl_rd_data
);
    // Handler mode is always privileged; in thread mode the field reads zero.
    always_comb begin
        priv_eff    = in_handler || !thread_unpriv;
        psr_exc     = in_handler ? act_exc : '0;
        ctl_rd_data = {{(CTRL_W-1){1'b0}}, thread_unpriv};
    end
endmodule

// File: rtl/exec_state_ctrl.sv
// Module: exec_state_ctrl (top)
// Mode and privilege controller: joins the mode tracker, the privilege
// register and the output view.
// Assumes: the sequencer sends single-cycle strobes. Exception numbers
// are nonzero. Only bit 0 of the control word is held.
module exec_state_ctrl
    import exec_state_pkg::*;
#(
    parameter int EXC_W    = 9,
    parameter int CTRL_W   = 32,
    parameter int IRQ_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              exc_is_irq,
    input  logic [EXC_W-1:0]  exc_num,
    input  logic              exc_ret,
    input  logic              ctl_wr_en,
    input  logic [CTRL_W-1:0] ctl_wr_data,
    output logic [CTRL_W-1:0] ctl_rd_data,
    output logic              in_handler,
    output logic              priv_eff,
    output logic [EXC_W-1:0]  psr_exc
);
    exec_mode_e       mode;
    logic [EXC_W-1:0] act_exc;
    logic             thread_unpriv;
    logic             unused_wr_hi;

    // Upper write bits are not held.
    assign unused_wr_hi = ^ctl_wr_data[CTRL_W-1:1];
    // Present the mode as a plain bit.
    assign in_handler   = (mode == MODE_HANDLER);

    mode_tracker #(.EXC_W(EXC_W), .IRQ_BASE(IRQ_BASE)) mode_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_is_irq(exc_is_irq),
        .exc_num(exc_num), .exc_ret(exc_ret), .mode(mode), .act_exc(act_exc)
    );

    priv_reg priv_i (
        .clk(clk), .rst_n(rst_n), .in_handler(in_handler), .wr_en(ctl_wr_en),
        .wr_bit0(ctl_wr_data[0]), .thread_unpriv(thread_unpriv)
    );

    status_view #(.EXC_W(EXC_W), .CTRL_W(CTRL_W)) view_i (
        .in_handler(in_handler), .thread_unpriv(thread_unpriv), .act_exc(act_exc),
        .priv_eff(priv_eff), .psr_exc(psr_exc), .ctl_rd_data(ctl_rd_data)
    );

    // R4: entry from thread mode lands in handler mode with privilege
    a_r4_entry_privileged: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && exc_req) |=> (in_handler && priv_eff))
        else $error("entry did not reach privileged handler mode");

    // R6: return from handler mode lands in thread mode
    a_r6_return_thread: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && exc_ret) |=> !in_handler)
        else $error("return did not reach thread mode");

    // R7: a raw exception number is recorded unchanged
    a_r7_raw_number: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && exc_req && !exc_is_irq) |=> (psr_exc == $past(exc_num)))
        else $error("exception field mismatch");

    // R5: a handler write of 0 restores privilege after the return
    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && ctl_wr_en && !ctl_wr_data[0] && !exc_ret) |=> (ctl_rd_data[0] == 1'b0))
        else $error("handler clear not taken");
endmodule

// File: tb/exec_state_ctrl_tb_top.sv
// Directed bench for exec_state_ctrl, one task per scenario.
module exec_state_ctrl_tb_top;
    localparam int EXC_W  = 9;
    localparam int CTRL_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              exc_req, exc_is_irq, exc_ret, ctl_wr_en;
    logic [EXC_W-1:0]  exc_num;
    logic [CTRL_W-1:0] ctl_wr_data;
    logic [CTRL_W-1:0] ctl_rd_data;
    logic              in_handler, priv_eff;
    logic [EXC_W-1:0]  psr_exc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exec_state_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_is_irq(exc_is_irq),
        .exc_num(exc_num), .exc_ret(exc_ret), .ctl_wr_en(ctl_wr_en),
        .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .in_handler(in_handler), .priv_eff(priv_eff), .psr_exc(psr_exc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle with the given strobes; sample 1 ns after the edge.
    task automatic cycle(input logic req, input logic irq, input logic [EXC_W-1:0] num,
                         input logic ret, input logic we, input logic [CTRL_W-1:0] wd);
        exc_req = req; exc_is_irq = irq; exc_num = num; exc_ret = ret;
        ctl_wr_en = we; ctl_wr_data = wd;
        @(posedge clk); #1;
        exc_req = 0; exc_is_irq = 0; exc_num = '0; exc_ret = 0; ctl_wr_en = 0; ctl_wr_data = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        cycle(0, 0, '0, 0, 0, '0);
        cycle(0, 0, '0, 0, 0, '0);
        rst_n = 1;
        chk("R1 mode", 32'(in_handler), 0);
        chk("R1 priv", 32'(priv_eff), 1);
        chk("R1 ctl", ctl_rd_data, 0);
        chk("R1 psr", 32'(psr_exc), 0);
    endtask

    task automatic t_drop_priv();
        cycle(0, 0, '0, 0, 1, 32'hFFFF_FFFF);
        chk("R2 priv dropped", 32'(priv_eff), 0);
        chk("R9 ctl upper zero", ctl_rd_data, 1);
    endtask

    task automatic t_locked();
        cycle(0, 0, '0, 0, 1, 32'h0);
        chk("R3 priv still low", 32'(priv_eff), 0);
        chk("R3 ctl still set", ctl_rd_data, 1);
    endtask

    task automatic t_irq_entry();
        cycle(1, 1, 9'd3, 0, 0, '0);
        chk("R4 handler", 32'(in_handler), 1);
        chk("R4 priv in handler", 32'(priv_eff), 1);
        chk("R8 irq3 as 19", 32'(psr_exc), 19);
        chk("R9 read in handler", ctl_rd_data, 1);
    endtask

    task automatic t_nested();
        cycle(1, 0, 9'd11, 0, 0, '0);
        chk("R10 nested field", 32'(psr_exc), 19);
        chk("R10 nested mode", 32'(in_handler), 1);
    endtask

    task automatic t_handler_clear();
        cycle(0, 0, '0, 0, 1, 32'h0);
        chk("R5 clear accepted", ctl_rd_data, 0);
        cycle(0, 0, '0, 1, 0, '0);
        chk("R6 thread after return", 32'(in_handler), 0);
        chk("R5 priv restored", 32'(priv_eff), 1);
        chk("R7 field zero in thread", 32'(psr_exc), 0);
    endtask

    task automatic t_stray_return();
        cycle(0, 0, '0, 1, 0, '0);
        chk("R10 stray return mode", 32'(in_handler), 0);
        chk("R10 stray return field", 32'(psr_exc), 0);
    endtask

    task automatic t_handler_set();
        cycle(1, 0, 9'd11, 0, 0, '0);
        chk("R7 raw number", 32'(psr_exc), 11);
        cycle(0, 0, '0, 0, 1, 32'h1);
        chk("R4 priv with bit set", 32'(priv_eff), 1);
        cycle(0, 0, '0, 1, 0, '0);
        chk("R5 unpriv after return", 32'(priv_eff), 0);
        cycle(1, 0, 9'd511, 0, 0, '0);
        chk("R7 top number", 32'(psr_exc), 511);
        cycle(0, 0, '0, 0, 1, 32'h0);
        cycle(0, 0, '0, 1, 0, '0);
        chk("R5 priv back", 32'(priv_eff), 1);
    endtask

    task automatic t_irq_max();
        cycle(1, 1, 9'd495, 0, 0, '0);
        chk("R8 line 495 as 511", 32'(psr_exc), 511);
        cycle(0, 0, '0, 1, 0, '0);
        chk("R6 thread again", 32'(in_handler), 0);
    endtask

    initial begin
        t_reset();
        t_drop_priv();
        t_locked();
        t_irq_entry();
        t_nested();
        t_handler_clear();
        t_stray_return();
        t_handler_set();
        t_irq_max();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule